// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard-control logic for a five-stage in-order integer pipeline: fetch, decode, execute, memory, writeback. Each cycle it looks at the valid flag, instruction class and register specifiers of the instructions sitting in decode, execute, memory and writeback. From these it drives the operand-bypass selects for the two execute-stage ALU inputs, a bypass select for store data in the memory stage, and bypass selects that feed decode-stage branch comparison. It also drives a data-hazard stall, a squash for the instruction fetched behind a taken branch, and the arbitration of a single memory port shared by fetch and the memory stage.

The controller is purely combinational. Its outputs steer the datapath registers in the same cycle. On a stall the program counter and the fetch/decode register hold, the decode/execute register loads a no-op, and the memory and writeback stages keep advancing. On a fetch hold only the fetch access waits for one cycle. On a flush the fetch/decode register loads a no-op. The register file is assumed to write in the first half of a cycle and read in the second half, so a writer in writeback never needs a bypass into decode.

Top module: `hzc_ctrl`

## Requirements
- R1: Class codes are 0 none, 1 ALU, 2 load, 3 store, 4 branch. Bypass select codes are 0 register file, 1 execute/memory ALU result, 2 memory/writeback result. An execute-stage operand (A for ALU, load and store; B for ALU and store) whose register matches the destination of a valid ALU instruction in memory gets select 1.
- R2: An execute-stage operand that matches the destination of a valid ALU or load instruction in writeback, and has no memory-stage match, gets select 2.
- R3: When both the memory-stage and the writeback-stage instructions match an operand, the younger one wins and the select is 1.
- R4: Register 0 never matches. A zero specifier yields select 0, causes no stall and sets no bypass.
- R5: A store in decode whose store-data register (rs2) is the destination of a load in execute, and whose base register is not, does not stall. `fwd_st_o` is 1 when a valid store in memory has a nonzero rs2 equal to the destination of a valid ALU or load instruction in writeback.
- R6: A valid load in execute whose destination matches an ALU operand of the decode instruction, or the base register of a load or store in decode, raises `stall_o`.
- R7: A branch in decode raises `stall_o` when either of its operands matches the destination of an ALU or load instruction in execute, or of a load in memory.
- R8: A branch operand in decode that matches the destination of an ALU instruction in memory sets `br_fwd_a_o` or `br_fwd_b_o` (1 = take the execute/memory result).
- R9: A valid branch in decode with `id_br_taken_i` = 1 raises `flush_o`, unless `stall_o` is 1 in that cycle, in which case `flush_o` is 0.
- R10: With `split_mem_i` = 0, a valid load or store in memory sets `port_mem_o` and `fetch_hold_o`. With `split_mem_i` = 1, both stay 0.
- R11: A stage whose valid flag is 0 causes no bypass, no stall, no flush and no port claim, whatever its class and specifiers.
- R12: A writer in writeback never causes a decode-stage stall or branch bypass, because the register file covers that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| split_mem_i | input | 1 | 1 = separate instruction and data memories |
| id_valid_i | input | 1 | Decode instruction valid |
| id_cls_i | input | 3 | Decode instruction class |
| id_rs1_i | input | REG_W | Decode first source register |
| id_rs2_i | input | REG_W | Decode second source register |
| id_br_taken_i | input | 1 | Branch comparison outcome in decode |
| ex_valid_i | input | 1 | Execute instruction valid |
| ex_cls_i | input | 3 | Execute instruction class |
| ex_rd_i | input | REG_W | Execute destination register |
| ex_rs1_i | input | REG_W | Execute first source register |
| ex_rs2_i | input | REG_W | Execute second source register |
| mem_valid_i | input | 1 | Memory instruction valid |
| mem_cls_i | input | 3 | Memory instruction class |
| mem_rd_i | input | REG_W | Memory destination register |
| mem_rs2_i | input | REG_W | Memory store-data register |
| wb_valid_i | input | 1 | Writeback instruction valid |
| wb_cls_i | input | 3 | Writeback instruction class |
| wb_rd_i | input | REG_W | Writeback destination register |
| fwd_a_o | output | 2 | Execute operand A select |
| fwd_b_o | output | 2 | Execute operand B select |
| fwd_st_o | output | 1 | Memory-stage store data from writeback |
| br_fwd_a_o | output | 1 | Decode branch operand A from execute/memory |
| br_fwd_b_o | output | 1 | Decode branch operand B from execute/memory |
| stall_o | output | 1 | Hold PC and fetch/decode, bubble into execute |
| flush_o | output | 1 | Squash the instruction behind a taken branch |
| fetch_hold_o | output | 1 | Fetch waits; port belongs to memory stage |
| port_mem_o | output | 1 | Shared port granted to memory stage |

## Verification
The bench builds the controller with REG_W = 5, which gives 32 registers. This lets the stimulus place distinct nonzero specifiers in every stage at once and still keep register 0 as a separate case. With that width, each bypass path, the load-to-store exemption and both branch stall causes can be set up with specifiers that collide only where a vector intends them to. The bench also drives the split-memory input both ways, so both arbitration variants are exercised in one build.

// File: rtl/hzc_pkg.sv
`timescale 1ns/1ps
package hzc_pkg;

    localparam int CLS_W = 3;
    localparam int FWD_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } iclass_e;

    typedef enum logic [FWD_W-1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EXMEM   = 2'd1,
        SRC_MEMWB   = 2'd2
    } fwd_src_e;

    // Destination-writing classes
    function automatic logic cls_writes(iclass_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

    // Execute stage consumes operand A (ALU input or address base)
    function automatic logic cls_ex_uses_a(iclass_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

    // Execute stage consumes operand B (ALU input or store data carried on)
    function automatic logic cls_ex_uses_b(iclass_e c);
        return (c == CLS_ALU) || (c == CLS_STORE);
    endfunction

    // Decode instruction needs rs1 as ALU operand or address base
    function automatic logic cls_needs_rs1_early(iclass_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

    function automatic logic cls_mem_access(iclass_e c);
        return (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

endpackage

// File: rtl/hzc_fwd_sel.sv
`timescale 1ns/1ps
module hzc_fwd_sel
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             use_i,
    input  logic [REG_W-1:0] src_i,
    input  logic             young_ok_i,
    input  logic [REG_W-1:0] young_rd_i,
    input  logic             old_ok_i,
    input  logic [REG_W-1:0] old_rd_i,
    output fwd_src_e         sel_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic live;
    logic young_hit;
    logic old_hit;

    assign live      = use_i && (src_i != ZERO_REG);
    assign young_hit = live && young_ok_i && (young_rd_i == src_i);
    assign old_hit   = live && old_ok_i && (old_rd_i == src_i);

    always_comb begin
        if (young_hit)    sel_o = SRC_EXMEM;
        else if (old_hit) sel_o = SRC_MEMWB;
        else              sel_o = SRC_REGFILE;
    end
endmodule

// File: rtl/hzc_hazard.sv
`timescale 1ns/1ps
module hzc_hazard
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             id_valid_i,
    input  iclass_e          id_cls_i,
    input  logic [REG_W-1:0] id_rs1_i,
    input  logic [REG_W-1:0] id_rs2_i,
    input  logic             ex_valid_i,
    input  iclass_e          ex_cls_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             mem_valid_i,
    input  iclass_e          mem_cls_i,
    input  logic [REG_W-1:0] mem_rd_i,
    output logic             stall_o,
    output logic             br_fwd_a_o,
    output logic             br_fwd_b_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic ex_writer, ex_loader, mem_loader, mem_alu;
    logic id_br, id_alu;
    logic hit_ex1, hit_ex2, hit_mem1, hit_mem2;
    logic load_use, br_on_ex, br_on_mem;

    assign ex_writer  = ex_valid_i && cls_writes(ex_cls_i) && (ex_rd_i != ZERO_REG);
    assign ex_loader  = ex_writer && (ex_cls_i == CLS_LOAD);
    assign mem_loader = mem_valid_i && (mem_cls_i == CLS_LOAD) && (mem_rd_i != ZERO_REG);
    assign mem_alu    = mem_valid_i && (mem_cls_i == CLS_ALU) && (mem_rd_i != ZERO_REG);

    assign id_br  = id_valid_i && (id_cls_i == CLS_BRANCH);
    assign id_alu = id_valid_i && (id_cls_i == CLS_ALU);

    assign hit_ex1  = (id_rs1_i == ex_rd_i);
    assign hit_ex2  = (id_rs2_i == ex_rd_i);
    assign hit_mem1 = (id_rs1_i == mem_rd_i);
    assign hit_mem2 = (id_rs2_i == mem_rd_i);

    // Loaded value needed as ALU input or address; store data alone is exempt
    assign load_use = ex_loader && id_valid_i &&
                      ((cls_needs_rs1_early(id_cls_i) && hit_ex1) ||
                       (id_alu && hit_ex2));

    // Branch compares in decode: nothing from execute can reach it in time
    assign br_on_ex  = id_br && ex_writer && (hit_ex1 || hit_ex2);
    assign br_on_mem = id_br && mem_loader && (hit_mem1 || hit_mem2);

    assign stall_o    = load_use || br_on_ex || br_on_mem;
    assign br_fwd_a_o = id_br && mem_alu && hit_mem1;
    assign br_fwd_b_o = id_br && mem_alu && hit_mem2;
endmodule

// File: rtl/hzc_port_arb.sv
`timescale 1ns/1ps
module hzc_port_arb
    import hzc_pkg::*;
(
    input  logic    split_mem_i,
    input  logic    mem_valid_i,
    input  iclass_e mem_cls_i,
    output logic    port_mem_o,
    output logic    fetch_hold_o
);
    logic mem_wants;

    assign mem_wants = mem_valid_i && cls_mem_access(mem_cls_i);

    // Memory stage has fixed priority on the shared port
    assign port_mem_o   = !split_mem_i && mem_wants;
    assign fetch_hold_o = port_mem_o;
endmodule

// File: rtl/hzc_ctrl.sv
`timescale 1ns/1ps
module hzc_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             split_mem_i,
    input  logic             id_valid_i,
    input  logic [2:0]       id_cls_i,
    input  logic [REG_W-1:0] id_rs1_i,
    input  logic [REG_W-1:0] id_rs2_i,
    input  logic             id_br_taken_i,
    input  logic             ex_valid_i,
    input  logic [2:0]       ex_cls_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic [REG_W-1:0] ex_rs1_i,
    input  logic [REG_W-1:0] ex_rs2_i,
    input  logic             mem_valid_i,
    input  logic [2:0]       mem_cls_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic [REG_W-1:0] mem_rs2_i,
    input  logic             wb_valid_i,
    input  logic [2:0]       wb_cls_i,
    input  logic [REG_W-1:0] wb_rd_i,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o,
    output logic             fwd_st_o,
    output logic             br_fwd_a_o,
    output logic             br_fwd_b_o,
    output logic             stall_o,
    output logic             flush_o,
    output logic             fetch_hold_o,
    output logic             port_mem_o
);
    localparam int N_EX_OPS = 2;

    iclass_e id_cls, ex_cls, mem_cls, wb_cls;
    assign id_cls  = iclass_e'(id_cls_i);
    assign ex_cls  = iclass_e'(ex_cls_i);
    assign mem_cls = iclass_e'(mem_cls_i);
    assign wb_cls  = iclass_e'(wb_cls_i);

    // Bypass sources: ALU result at execute/memory, any writer at memory/writeback
    logic young_src_ok, old_src_ok;
    assign young_src_ok = mem_valid_i && (mem_cls == CLS_ALU);
    assign old_src_ok   = wb_valid_i && cls_writes(wb_cls);

    logic [REG_W-1:0] ex_src  [N_EX_OPS];
    logic             ex_use  [N_EX_OPS];
    fwd_src_e         ex_sel  [N_EX_OPS];

    assign ex_src[0] = ex_rs1_i;
    assign ex_src[1] = ex_rs2_i;
    assign ex_use[0] = ex_valid_i && cls_ex_uses_a(ex_cls);
    assign ex_use[1] = ex_valid_i && cls_ex_uses_b(ex_cls);

    for (genvar g = 0; g < N_EX_OPS; g++) begin : g_ex_op
        hzc_fwd_sel #(.REG_W(REG_W)) u_sel (
            .use_i      (ex_use[g]),
            .src_i      (ex_src[g]),
            .young_ok_i (young_src_ok),
            .young_rd_i (mem_rd_i),
            .old_ok_i   (old_src_ok),
            .old_rd_i   (wb_rd_i),
            .sel_o      (ex_sel[g])
        );
    end

    assign fwd_a_o = ex_sel[0];
    assign fwd_b_o = ex_sel[1];

    // Store data in memory stage: only the writeback source applies
    fwd_src_e st_sel;
    hzc_fwd_sel #(.REG_W(REG_W)) u_st_sel (
        .use_i      (mem_valid_i && (mem_cls == CLS_STORE)),
        .src_i      (mem_rs2_i),
        .young_ok_i (1'b0),
        .young_rd_i (mem_rd_i),
        .old_ok_i   (old_src_ok),
        .old_rd_i   (wb_rd_i),
        .sel_o      (st_sel)
    );
    assign fwd_st_o = (st_sel == SRC_MEMWB);

    logic stall_w;
    hzc_hazard #(.REG_W(REG_W)) u_haz (
        .id_valid_i  (id_valid_i),
        .id_cls_i    (id_cls),
        .id_rs1_i    (id_rs1_i),
        .id_rs2_i    (id_rs2_i),
        .ex_valid_i  (ex_valid_i),
        .ex_cls_i    (ex_cls),
        .ex_rd_i     (ex_rd_i),
        .mem_valid_i (mem_valid_i),
        .mem_cls_i   (mem_cls),
        .mem_rd_i    (mem_rd_i),
        .stall_o     (stall_w),
        .br_fwd_a_o  (br_fwd_a_o),
        .br_fwd_b_o  (br_fwd_b_o)
    );
    assign stall_o = stall_w;

    // A stalled branch has not resolved yet; squash waits for it
    assign flush_o = id_valid_i && (id_cls == CLS_BRANCH) && id_br_taken_i && !stall_w;

    hzc_port_arb u_arb (
        .split_mem_i  (split_mem_i),
        .mem_valid_i  (mem_valid_i),
        .mem_cls_i    (mem_cls),
        .port_mem_o   (port_mem_o),
        .fetch_hold_o (fetch_hold_o)
    );
endmodule

// File: rtl/hzc_ctrl_chk.sv
`timescale 1ns/1ps
module hzc_ctrl_chk #(
    parameter int REG_W = 5
) (
    input logic             split_mem_i,
    input logic             id_valid_i,
    input logic [2:0]       id_cls_i,
    input logic             ex_valid_i,
    input logic [REG_W-1:0] ex_rs1_i,
    input logic [REG_W-1:0] ex_rs2_i,
    input logic             mem_valid_i,
    input logic [2:0]       mem_cls_i,
    input logic             wb_valid_i,
    input logic [1:0]       fwd_a_o,
    input logic [1:0]       fwd_b_o,
    input logic             fwd_st_o,
    input logic             br_fwd_a_o,
    input logic             br_fwd_b_o,
    input logic             stall_o,
    input logic             flush_o,
    input logic             fetch_hold_o,
    input logic             port_mem_o
);
    always_comb begin
        // R9: a stall suppresses the branch squash
        a_r9_stall_over_flush: assert (!(stall_o && flush_o));
        // R10: split memories never hold fetch
        a_r10_split_frees_fetch: assert (!(split_mem_i && (fetch_hold_o || port_mem_o)));
        // R5: store-data bypass only for a live store with a live writeback source
        if (fwd_st_o) begin
            a_r5_store_fwd_source: assert (mem_valid_i && (mem_cls_i == 3'd3) && wb_valid_i);
        end
        // R4: register 0 never selects a bypass
        if (ex_rs1_i == '0) begin
            a_r4_zero_a: assert (fwd_a_o == 2'd0);
        end
        if (ex_rs2_i == '0) begin
            a_r4_zero_b: assert (fwd_b_o == 2'd0);
        end
        // R11: an idle decode slot causes no stall, squash or branch bypass
        if (!id_valid_i) begin
            a_r11_idle_decode: assert (!stall_o && !flush_o && !br_fwd_a_o && !br_fwd_b_o);
        end
        // R8: branch bypass only for a branch in decode
        if (br_fwd_a_o || br_fwd_b_o) begin
            a_r8_branch_only: assert (id_valid_i && (id_cls_i == 3'd4) && mem_valid_i);
        end
        // R6: a stall needs a live producer ahead of decode
        if (stall_o) begin
            a_r6_stall_has_producer: assert (ex_valid_i || mem_valid_i);
        end
    end
endmodule

bind hzc_ctrl hzc_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hzc_ctrl_test.sv
`timescale 1ns/1ps
module hzc_ctrl_test;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          split_mem, id_valid, id_tk, ex_valid, mem_valid, wb_valid;
    logic [2:0]    id_cls, ex_cls, mem_cls, wb_cls;
    logic [RW-1:0] id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd;
    logic [1:0]    fwd_a, fwd_b;
    logic          fwd_st, bfa, bfb, stall, flush, fhold, pmem;

    hzc_ctrl #(.REG_W(RW)) uut (
        .split_mem_i(split_mem), .id_valid_i(id_valid), .id_cls_i(id_cls),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_br_taken_i(id_tk),
        .ex_valid_i(ex_valid), .ex_cls_i(ex_cls), .ex_rd_i(ex_rd),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
        .mem_valid_i(mem_valid), .mem_cls_i(mem_cls), .mem_rd_i(mem_rd), .mem_rs2_i(mem_rs2),
        .wb_valid_i(wb_valid), .wb_cls_i(wb_cls), .wb_rd_i(wb_rd),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .fwd_st_o(fwd_st),
        .br_fwd_a_o(bfa), .br_fwd_b_o(bfb), .stall_o(stall), .flush_o(flush),
        .fetch_hold_o(fhold), .port_mem_o(pmem)
    );

    typedef struct packed {
        logic split; logic [2:0] idc; logic [4:0] id1; logic [4:0] id2; logic tk;
        logic [2:0] exc; logic [4:0] exrd; logic [4:0] ex1; logic [4:0] ex2;
        logic [2:0] mc; logic [4:0] mrd; logic [4:0] m2;
        logic [2:0] wc; logic [4:0] wrd;
        logic [1:0] fa; logic [1:0] fb; logic fst; logic bfa; logic bfb;
        logic stl; logic fl; logic fh; logic pm; logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    // Classes: 0 none, 1 ALU, 2 load, 3 store, 4 branch
    localparam vec_t VECS [NV] = '{
        '{0, 0,0,0,0, 1,7,3,4,    1,3,0,  0,0,  1,0,0,0,0,0,0,0,0, 1},  // R1
        '{0, 0,0,0,0, 1,7,5,6,    0,0,0,  2,6,  0,2,0,0,0,0,0,0,0, 2},  // R2
        '{0, 0,0,0,0, 1,7,8,8,    1,8,0,  1,8,  1,1,0,0,0,0,0,0,0, 3},  // R3
        '{0, 0,0,0,0, 3,0,9,10,   1,10,0, 1,9,  2,1,0,0,0,0,0,0,0, 3},  // R3
        '{0, 0,0,0,0, 1,7,0,0,    1,0,0,  1,0,  0,0,0,0,0,0,0,0,0, 4},  // R4
        '{0, 1,0,0,0, 2,0,1,0,    0,0,0,  0,0,  0,0,0,0,0,0,0,0,0, 4},  // R4
        '{0, 3,2,11,0, 2,11,3,0,  0,0,0,  0,0,  0,0,0,0,0,0,0,0,0, 5},  // R5
        '{0, 0,0,0,0, 0,0,0,0,    3,0,11, 2,11, 0,0,1,0,0,0,0,1,1, 5},  // R5
        '{0, 1,4,12,0, 2,12,1,0,  0,0,0,  0,0,  0,0,0,0,0,1,0,0,0, 6},  // R6
        '{0, 2,12,0,0, 2,12,1,0,  0,0,0,  0,0,  0,0,0,0,0,1,0,0,0, 6},  // R6
        '{0, 3,12,5,0, 2,12,1,0,  0,0,0,  0,0,  0,0,0,0,0,1,0,0,0, 6},  // R6
        '{0, 4,13,14,1, 1,14,1,2, 0,0,0,  0,0,  0,0,0,0,0,1,0,0,0, 7},  // R7 R9
        '{0, 4,15,1,0, 0,0,0,0,   2,15,0, 0,0,  0,0,0,0,0,1,0,1,1, 7},  // R7 R10
        '{0, 4,16,17,1, 0,0,0,0,  1,17,0, 0,0,  0,0,0,0,1,0,1,0,0, 8},  // R8 R9
        '{1, 0,0,0,0, 0,0,0,0,    2,3,0,  0,0,  0,0,0,0,0,0,0,0,0, 10}, // R10
        '{0, 4,18,19,1, 0,0,0,0,  0,0,0,  1,18, 0,0,0,0,0,0,1,0,0, 12}, // R12
        '{0, 1,18,19,0, 0,0,0,0,  0,0,0,  2,19, 0,0,0,0,0,0,0,0,0, 12}  // R12
    };

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(string what, int req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        split_mem = 0; id_valid = 0; id_cls = 0; id_rs1 = 0; id_rs2 = 0; id_tk = 0;
        ex_valid = 0; ex_cls = 0; ex_rd = 0; ex_rs1 = 0; ex_rs2 = 0;
        mem_valid = 0; mem_cls = 0; mem_rd = 0; mem_rs2 = 0;
        wb_valid = 0; wb_cls = 0; wb_rd = 0;
    endtask

    task automatic apply(vec_t v);
        split_mem = v.split;
        id_cls = v.idc; id_valid = (v.idc != 0); id_rs1 = v.id1; id_rs2 = v.id2; id_tk = v.tk;
        ex_cls = v.exc; ex_valid = (v.exc != 0); ex_rd = v.exrd; ex_rs1 = v.ex1; ex_rs2 = v.ex2;
        mem_cls = v.mc; mem_valid = (v.mc != 0); mem_rd = v.mrd; mem_rs2 = v.m2;
        wb_cls = v.wc; wb_valid = (v.wc != 0); wb_rd = v.wrd;
    endtask

    task automatic check_all(vec_t v);
        int r = int'(v.req);
        chk("fwd_a", r, fwd_a, v.fa);
        chk("fwd_b", r, fwd_b, v.fb);
        chk("fwd_st", r, fwd_st, v.fst);
        chk("br_fwd_a", r, bfa, v.bfa);
        chk("br_fwd_b", r, bfb, v.bfb);
        chk("stall", r, stall, v.stl);
        chk("flush", r, flush, v.fl);
        chk("fetch_hold", r, fhold, v.fh);
        chk("port_mem", r, pmem, v.pm);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11: idle pipeline gives all-quiet outputs
        chk("idle stall", 11, stall, 0);
        chk("idle flush", 11, flush, 0);
        chk("idle fwd_a", 11, fwd_a, 0);
        chk("idle port", 11, pmem, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            check_all(VECS[i]);
        end

        // R11: invalid load in execute cannot stall a matching ALU in decode
        @(negedge clk); idle();
        id_valid = 1; id_cls = 1; id_rs1 = 12;
        ex_valid = 0; ex_cls = 2; ex_rd = 12;
        #1; chk("invalid ex load stall", 11, stall, 0);

        // R11: invalid ALU in memory is no bypass source and claims no port
        @(negedge clk); idle();
        ex_valid = 1; ex_cls = 1; ex_rs1 = 3;
        mem_valid = 0; mem_cls = 1; mem_rd = 3;
        #1; chk("invalid mem fwd_a", 11, fwd_a, 0);
        @(negedge clk); mem_cls = 2;
        #1; chk("invalid mem port", 11, pmem, 0);
        chk("invalid mem hold", 11, fhold, 0);

        // R11: invalid taken branch raises no flush
        @(negedge clk); idle();
        id_valid = 0; id_cls = 4; id_tk = 1;
        #1; chk("invalid branch flush", 11, flush, 0);

        // R9: untaken valid branch, no hazard, no flush
        @(negedge clk); idle();
        id_valid = 1; id_cls = 4; id_rs1 = 2; id_rs2 = 3; id_tk = 0;
        #1; chk("untaken flush", 9, flush, 0);

        // R10: store in memory with unified port
        @(negedge clk); idle();
        mem_valid = 1; mem_cls = 3; mem_rs2 = 0;
        #1; chk("store port", 10, pmem, 1);
        chk("store fetch hold", 10, fhold, 1);
        chk("store zero data fwd", 4, fwd_st, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule